// File: doc/BRIEF.md
# Byte-Bus Multiply/Divide Unit

This block is an arithmetic helper that sits on a byte-wide register bus. Software loads two 16-bit factors into an operand word, and when all four bytes of that word have been written, the unit forms their product. The product is signed or unsigned, and the unit can optionally add it into an accumulator. The same unit also performs an unsigned 32-by-32 division. Software starts the division with a control write, then polls a busy bit. The busy bit clears itself after a fixed number of cycles.

There are three 32-bit registers and one control byte. Operand word X holds the two factors and, after a division, the quotient. Word Y receives the product and supplies the divisor. Word Z is the accumulator, and after a division it holds the remainder. A mode field in the control byte selects the multiply flavour. The division uses a restoring divider that settles two quotient bits per cycle.

Top module: `mdu_top`

## Requirements
- R1: After reset every register reads zero. `rdata` is zero whenever `rd_en` is low, and reads of addresses 13 to 15 return zero.
- R2: The register map is little-endian. X is at addresses 0-3, and bytes 0-1 form the low factor and bytes 2-3 the high factor. Y is at 4-7, Z is at 8-11 and the control byte is at 12.
- R3: A multiply fires on the cycle after the last of the four distinct X bytes has been written, and the byte-tracking flags then clear. Writing fewer distinct bytes, including writing one byte twice, starts nothing.
- R4: The mode is given by control bits 7, 6 and 3. Value 0x00 is an unsigned multiply, 0x08 a signed multiply, 0x40 an unsigned multiply-accumulate and 0x48 a signed multiply-accumulate. Any mode with bit 7 set performs no multiply.
- R5: The product of the low factor and the high factor is written to Y. In the signed modes each factor is sign-extended from 16 bits first.
- R6: In the accumulate modes Z also becomes Z plus the product, taken modulo 2^32.
- R7: A control write with bits 7 and 0 both set starts a division of X by Y. Control bit 0 reads 1 only while a division runs. A write that sets bit 0 without bit 7 stores it as 0.
- R8: Bit 0 reads 1 for exactly 16 cycles after the starting write. It then clears, X holds the unsigned quotient and Z the remainder.
- R9: A division by zero yields all-ones in both X and Z.
- R10: While a division runs, writes to X, Y and the control byte are ignored. This includes the X byte flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data byte |

## Verification
The bench drives the multiply with several kinds of factors, and each kind exposes a different fault:
- Small values catch byte ordering and half-selection faults.
- All-ones factors give 0xFFFE0001 unsigned but 1 signed, so they separate the two sign treatments.
- Factors of 0x8000 check the most negative value, where a wrong sign extension shows up as a wrong top bit.
- An accumulator of 0xFFFFFFFF checks wrap-around.

The divider is exercised with three cases:
- a quotient that has a remainder, which checks the bit order of quotient and remainder;
- a large dividend divided by 2^16, which checks that all 32 steps are performed;
- a zero divisor.

Partial and repeated X writes, a mode with bit 7 set, and bus writes made during a division show whether triggers and writes are ignored exactly when required.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned DIV_STEPS = 2;
  localparam int unsigned DIV_LAT   = WORD_W / DIV_STEPS;

  typedef struct packed {
    logic [WORD_W-1:0] rem;
    logic [WORD_W-1:0] quo;
  } div_state_t;

  // Product of two half-words, optionally treating them as two's complement.
  function automatic logic [WORD_W-1:0] mul_half(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y,
                                                 input logic sgn);
    logic [WORD_W-1:0] xe, ye;
    xe = {{HALF_W{sgn & x[HALF_W-1]}}, x};
    ye = {{HALF_W{sgn & y[HALF_W-1]}}, y};
    return xe * ye;
  endfunction

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  function automatic div_state_t div_step(input div_state_t s, input logic [WORD_W-1:0] d);
    div_state_t  n;
    logic [WORD_W:0] sh;
    sh    = {s.rem, s.quo[WORD_W-1]};
    n.quo = {s.quo[WORD_W-2:0], 1'b0};
    if (sh >= {1'b0, d}) begin
      n.rem    = sh[WORD_W-1:0] - d;
      n.quo[0] = 1'b1;
    end else begin
      n.rem = sh[WORD_W-1:0];
    end
    return n;
  endfunction
endpackage

// File: rtl/mdu_mac.sv
module mdu_mac
  import mdu_pkg::*;
(
  input  logic [WORD_W-1:0] factors,
  input  logic              sgn,
  input  logic [WORD_W-1:0] acc_in,
  output logic [WORD_W-1:0] prod,
  output logic [WORD_W-1:0] acc_sum
);
  always_comb begin
    prod    = mul_half(factors[HALF_W-1:0], factors[WORD_W-1:HALF_W], sgn);
    acc_sum = acc_in + prod;
  end
endmodule

// File: rtl/mdu_divider.sv
module mdu_divider
  import mdu_pkg::*;
#(
  parameter int unsigned STEPS = DIV_STEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] quotient,
  output logic [WORD_W-1:0] remainder
);
  localparam int unsigned LAT   = WORD_W / STEPS;
  localparam int unsigned CNT_W = $clog2(LAT);

  div_state_t        st_q;
  logic [WORD_W-1:0] dsr_q;
  logic [CNT_W-1:0]  cnt_q;
  div_state_t        chain [STEPS+1];

  assign chain[0] = st_q;
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = div_step(chain[g], dsr_q);
  end

  assign done      = busy && (cnt_q == CNT_W'(LAT - 1));
  assign quotient  = (dsr_q == '0) ? '1 : chain[STEPS].quo;
  assign remainder = (dsr_q == '0) ? '1 : chain[STEPS].rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      st_q  <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      st_q  <= '{rem: '0, quo: dividend};
      dsr_q <= divisor;
      cnt_q <= '0;
    end else if (busy) begin
      st_q  <= chain[STEPS];
      cnt_q <= cnt_q + 1'b1;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata
);
  localparam int unsigned NB     = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(NB);
  localparam int unsigned SEL_W  = ADDR_W - LANE_W;
  localparam logic [SEL_W-1:0] SEL_X = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_Y = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_Z = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_K = SEL_W'(3);
  localparam int unsigned B_GO  = 0;
  localparam int unsigned B_SGN = 3;
  localparam int unsigned B_ACC = 6;
  localparam int unsigned B_OFF = 7;

  logic [WORD_W-1:0] a_q, b_q, c_q;
  logic [7:0]        ctl_q;
  logic [NB-1:0]     aflag_q, aflag_next;
  logic              mul_go;

  logic [SEL_W-1:0]  reg_sel;
  logic [LANE_W-1:0] lane;
  logic              busy, wr_a, wr_b, wr_c, wr_ctl, a_full, mul_en, div_start;
  logic              div_busy, div_done;
  logic [WORD_W-1:0] div_quo, div_rem, prod, mac_sum;

  assign reg_sel    = addr[ADDR_W-1:LANE_W];
  assign lane       = addr[LANE_W-1:0];
  assign busy       = ctl_q[B_GO];
  assign wr_a       = wr_en && reg_sel == SEL_X && !busy;
  assign wr_b       = wr_en && reg_sel == SEL_Y && !busy;
  assign wr_c       = wr_en && reg_sel == SEL_Z;
  assign wr_ctl     = wr_en && reg_sel == SEL_K && lane == '0 && !busy;
  assign aflag_next = aflag_q | (NB'(1) << lane);
  assign a_full     = wr_a && (&aflag_next);
  assign div_start  = wr_ctl && wdata[B_OFF] && wdata[B_GO];
  assign mul_en     = mul_go && !ctl_q[B_OFF];

  mdu_mac u_mac (
    .factors (a_q),
    .sgn     (ctl_q[B_SGN]),
    .acc_in  (c_q),
    .prod    (prod),
    .acc_sum (mac_sum)
  );

  mdu_divider u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .dividend  (a_q),
    .divisor   (b_q),
    .busy      (div_busy),
    .done      (div_done),
    .quotient  (div_quo),
    .remainder (div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      ctl_q   <= '0;
      aflag_q <= '0;
      mul_go  <= 1'b0;
    end else begin
      mul_go <= a_full;
      if (wr_a) begin
        a_q[{lane, 3'b000} +: 8] <= wdata;
        aflag_q <= a_full ? '0 : aflag_next;
      end
      if (wr_b) b_q[{lane, 3'b000} +: 8] <= wdata;
      if (wr_c) c_q[{lane, 3'b000} +: 8] <= wdata;
      if (wr_ctl) ctl_q <= {wdata[7:1], wdata[B_OFF] & wdata[B_GO]};
      if (mul_en) begin
        b_q <= prod;
        if (ctl_q[B_ACC]) c_q <= mac_sum;
      end
      if (div_done) begin
        a_q         <= div_quo;
        c_q         <= div_rem;
        ctl_q[B_GO] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (reg_sel)
        SEL_X:   rdata = a_q[{lane, 3'b000} +: 8];
        SEL_Y:   rdata = b_q[{lane, 3'b000} +: 8];
        SEL_Z:   rdata = c_q[{lane, 3'b000} +: 8];
        default: rdata = (lane == '0) ? ctl_q : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              div_start,
  input logic              div_done,
  input logic              div_busy,
  input logic              ctl_busy,
  input logic [WORD_W-1:0] a_q,
  input logic [WORD_W-1:0] b_q,
  input logic [WORD_W-1:0] quo,
  input logic [WORD_W-1:0] rem,
  input logic              mul_go,
  input logic [3:0]        aflag
);
  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         lat_cnt <= '0;
    else if (div_start) lat_cnt <= '0;
    else if (div_busy)  lat_cnt <= lat_cnt + 1'b1;
  end

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> ctl_busy);
  p_busy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy == div_busy);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> lat_cnt == 8'(DIV_LAT - 1));
  p_clear_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> !ctl_busy);
  p_zero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && b_q == '0) |-> (quo == '1 && rem == '1));
  p_hold_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_busy && !div_done) |=> $stable(a_q));
  p_hold_y_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy |=> $stable(b_q));
  p_flags_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> aflag == 4'b0000);
endmodule

bind mdu_top mdu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_start (div_start),
  .div_done  (div_done),
  .div_busy  (div_busy),
  .ctl_busy  (ctl_q[0]),
  .a_q       (a_q),
  .b_q       (b_q),
  .quo       (div_quo),
  .rem       (div_rem),
  .mul_go    (mul_go),
  .aflag     (aflag_q)
);

// File: tb/tb_mdu_top.sv
module tb_mdu_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [3:0]  base;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  mdu_top dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
               .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr32(input logic [3:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 4'(i), v[8*i +: 8]);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd8(base + 4'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic expect_reg(input logic [3:0] base, input logic [31:0] v, input string tag);
    sb.push_back('{base: base, val: v, tag: tag});
  endtask

  // Monitor: pops every pending expectation and compares it with the bus view.
  task automatic monitor();
    logic [31:0] got;
    logic [7:0]  b;
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      if (e.base == 4'd12) begin
        rd8(e.base, b);
        got = {24'h0, b};
      end else begin
        rd32(e.base, got);
      end
      check(e.tag, got, e.val);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] lo, input logic [15:0] hi, input bit sgn);
    longint x, y, p;
    x = sgn ? longint'($signed(lo)) : longint'(lo);
    y = sgn ? longint'($signed(hi)) : longint'(hi);
    p = x * y;
    return p[31:0];
  endfunction

  task automatic mul_op(input logic [7:0] mode, input logic [15:0] lo, input logic [15:0] hi,
                        input logic [31:0] z0, input string tag);
    logic [31:0] p;
    wr(4'd12, mode);
    wr32(4'd8, z0);
    wr32(4'd0, {hi, lo});
    @(negedge clk);
    p = ref_mul(lo, hi, mode[3]);
    expect_reg(4'd4, p, {tag, " product R5 R4"});
    expect_reg(4'd8, mode[6] ? z0 + p : z0, {tag, " accumulator R6"});
    monitor();
  endtask

  task automatic wait_idle(output int cycles);
    logic [7:0] k;
    cycles = 0;
    for (int i = 0; i < 100; i++) begin
      rd8(4'd12, k);
      if (!k[0]) break;
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic div_op(input logic [31:0] a, input logic [31:0] b, input string tag);
    int cyc;
    wr(4'd12, 8'h80);
    wr32(4'd0, a);
    wr32(4'd4, b);
    wr(4'd12, 8'h81);
    wait_idle(cyc);
    check({tag, " busy length R8"}, 32'(cyc), 32'd16);
    expect_reg(4'd0, (b == 0) ? 32'hFFFF_FFFF : a / b, {tag, " quotient R8 R9"});
    expect_reg(4'd8, (b == 0) ? 32'hFFFF_FFFF : a % b, {tag, " remainder R8 R9"});
    expect_reg(4'd12, 32'h80, {tag, " go bit cleared R8"});
    monitor();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b8;
    logic [31:0] w;
    int          cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and read gating
    expect_reg(4'd0, 32'h0, "R1 reset X");
    expect_reg(4'd4, 32'h0, "R1 reset Y");
    expect_reg(4'd8, 32'h0, "R1 reset Z");
    expect_reg(4'd12, 32'h0, "R1 reset control");
    monitor();

    // R2: byte lanes land in little-endian order
    wr32(4'd8, 32'hA1B2_C3D4);
    rd8(4'd8, b8);  check("R2 Z byte 0", {24'h0, b8}, 32'hD4);
    rd8(4'd11, b8); check("R2 Z byte 3", {24'h0, b8}, 32'hA1);
    addr = 4'd8; rd_en = 1'b0; #1 check("R1 rd_en low", {24'h0, rdata}, 32'h0);
    rd8(4'd13, b8); check("R1 unmapped read", {24'h0, b8}, 32'h0);

    // R4 R5 R6: all modes
    mul_op(8'h00, 16'd3, 16'd5, 32'd0, "unsigned small");
    mul_op(8'h00, 16'hFFFF, 16'hFFFF, 32'd0, "unsigned ones");
    mul_op(8'h08, 16'hFFFF, 16'hFFFF, 32'd0, "signed ones");
    mul_op(8'h08, 16'h8000, 16'h8000, 32'd0, "signed min*min");
    mul_op(8'h08, 16'h8000, 16'h7FFF, 32'd0, "signed min*max");
    mul_op(8'h40, 16'd2, 16'd3, 32'd100, "mac unsigned");
    mul_op(8'h40, 16'd1, 16'd1, 32'hFFFF_FFFF, "mac wrap");
    mul_op(8'h48, 16'hFFFF, 16'd2, 32'd10, "mac signed");
    mul_op(8'h48, 16'h8000, 16'h8000, 32'h8000_0000, "mac signed min");

    // R4: a mode with bit 7 set performs no multiply
    wr32(4'd4, 32'h1234_5678);
    wr(4'd12, 8'hC8);
    wr32(4'd0, 32'h0002_0003);
    @(negedge clk);
    expect_reg(4'd4, 32'h1234_5678, "R4 disabled mode leaves Y");
    monitor();

    // R3: partial and repeated writes start nothing; the fourth distinct byte does
    wr(4'd12, 8'h00);
    wr32(4'd4, 32'hDEAD_BEEF);
    wr(4'd0, 8'h07); wr(4'd1, 8'h00); wr(4'd2, 8'h09); wr(4'd2, 8'h06);
    @(negedge clk);
    expect_reg(4'd4, 32'hDEAD_BEEF, "R3 three bytes no multiply");
    monitor();
    wr(4'd3, 8'h00);
    @(negedge clk);
    expect_reg(4'd4, 32'd42, "R3 fourth byte triggers");
    monitor();

    // R7: go bit without bit 7 is stored as zero
    wr(4'd12, 8'h01);
    expect_reg(4'd12, 32'h00, "R7 go without enable");
    expect_reg(4'd12, 32'h00, "R7 no divide started");
    monitor();

    // R8 R9: divisions
    div_op(32'd100, 32'd7, "div 100/7");
    div_op(32'hFFFF_FFFF, 32'h0001_0000, "div big");
    div_op(32'h8765_4321, 32'd0, "div zero");

    // R10: writes during a running division are ignored
    wr(4'd12, 8'h80);
    wr32(4'd0, 32'd1000);
    wr32(4'd4, 32'd30);
    wr(4'd12, 8'h81);
    wr(4'd4, 8'h55);
    wr(4'd12, 8'h00);
    wr(4'd0, 8'h99);
    rd8(4'd12, b8);
    check("R10 control write ignored while busy", {24'h0, b8}, 32'h81);
    wait_idle(cyc);
    expect_reg(4'd4, 32'd30, "R10 Y write ignored");
    expect_reg(4'd0, 32'd33, "R10 quotient from original X");
    expect_reg(4'd8, 32'd10, "R10 remainder from original X");
    monitor();
    wr(4'd12, 8'h00);
    wr(4'd1, 8'h00); wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    @(negedge clk);
    rd32(4'd4, w);
    check("R10 X flag not set while busy", w, 32'd30);
    wr(4'd0, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule